// File: doc/BRIEF.md
# Home-Node Cache Line Directory Controller

This block is the directory logic that sits at one node of a 256-node distributed shared-memory machine. Requests arrive from the interconnect one at a time. Each request carries the number of the node asking for a line and a 32-bit physical address. The controller splits the address into a home node number, a line index and a byte offset. It rejects any request whose home node is not this node. For a local line, it looks up the directory entry that records whether the line is cached, and where.

A line may sit in at most one cache at a time. If another node holds the line, the controller first sends a recall to that holder and waits for its acknowledgement. It then issues a read of the line from local RAM. When the data returns, it sends the data back to the requester and records the requester as the new holder. The RAM and the network fabric are outside the block: the block drives a one-cycle read strobe and waits for a data-valid pulse, and it holds a recall request up until it is acknowledged.

The directory depth is set by a parameter. The real layout has one entry per 64-byte line of a 16 MB node, which is 2^18 entries. A smaller build keeps the field positions and indexes with the low bits of the line field.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid`, `ram_rd` and `rcl_valid` are 0, and every directory entry reads as uncached, so the first request to any line causes no recall.
- R2: Address bits 31:24 are the home node, bits 23:6 the line index (the directory uses its low IDX_W bits) and bits 5:0 the byte offset. Two addresses that differ only in the offset select the same entry. For example, address 0x24000108 is home 36, line 4, offset 8.
- R3: A request whose home field differs from NODE_ID gets one reply with `rsp_err`=1 and `rsp_data`=0. It causes no RAM read and no recall, and it leaves the directory unchanged.
- R4: A request to a local line that is uncached pulses `ram_rd` for one cycle with `ram_line` set to the entry index. The RAM data is then returned in a single-cycle reply, with `rsp_dst` set to the requester, `rsp_err`=0 and `rsp_addr` echoing the request address.
- R5: Once the RAM data arrives, the entry records the requester as the sole holder. A later request from a different node for that entry drives a recall with `rcl_node` set to that holder and `rcl_line` set to the index.
- R6: `rcl_valid` stays high, with a stable `rcl_node`, until `rcl_ack`. No RAM read is issued while the recall is pending, and the line is fetched only after the acknowledgement.
- R7: A request from the node that already holds the line causes no recall. The line is fetched and granted again.
- R8: Exactly one request is in progress at a time. `req_ready` is low from the cycle after acceptance until the reply has been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_src | input | 8 | Requesting node number |
| req_addr | input | 32 | Physical address of the request |
| rcl_valid | output | 1 | Recall request to the current holder |
| rcl_node | output | 8 | Node to recall the line from |
| rcl_line | output | IDX_W | Directory index being recalled |
| rcl_ack | input | 1 | Holder has given up the line |
| ram_rd | output | 1 | One-cycle local RAM line read strobe |
| ram_line | output | IDX_W | Line index to read |
| ram_rvalid | input | 1 | RAM read data valid |
| ram_rdata | input | DATA_W | RAM line data |
| rsp_valid | output | 1 | Reply valid for one cycle |
| rsp_dst | output | 8 | Node the reply goes to |
| rsp_err | output | 1 | Request rejected: not the home node |
| rsp_addr | output | 32 | Echo of the request address |
| rsp_data | output | DATA_W | Line data, zero on error |

## Verification
Directed requests come first. They cover the decode example, a repeat request from the same holder with a different offset, a request from a second node that must recall the first holder, and a foreign-home request followed by a probe that shows the directory kept its holder. These separate the no-recall, recall and reject paths. After them, a seeded random mix runs over a 16-entry directory. Most addresses are local, and the requesting nodes are drawn from a small set, so lines change hands often. A reference array predicts for each request whether a recall happens, which node it targets, the RAM index, the reply data, and that no RAM read overlaps a recall.

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
  parameter logic [7:0] NODE_ID = 8'd0,
  parameter int IDX_W  = 10,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_src,
  input  logic [31:0]       req_addr,
  output logic              rcl_valid,
  output logic [7:0]        rcl_node,
  output logic [IDX_W-1:0]  rcl_line,
  input  logic              rcl_ack,
  output logic              ram_rd,
  output logic [IDX_W-1:0]  ram_line,
  input  logic              ram_rvalid,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_dst,
  output logic              rsp_err,
  output logic [31:0]       rsp_addr,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int ENTRIES = 1 << IDX_W;

  typedef enum logic [2:0] {S_IDLE, S_RCL, S_FETCH, S_WAIT, S_RSP} st_t;
  st_t st;

  logic [7:0]        cur_src, hold_q;
  logic [31:0]       cur_addr;
  logic              err_q;
  logic [DATA_W-1:0] data_q;
  logic              dir_v [ENTRIES];
  logic [7:0]        dir_h [ENTRIES];

  wire [7:0]       a_home = req_addr[31:24];
  wire [17:0]      a_line = req_addr[23:6];
  wire [IDX_W-1:0] a_idx  = a_line[IDX_W-1:0];
  wire [IDX_W-1:0] c_idx  = cur_addr[6 +: IDX_W];
  wire             accept = req_valid && (st == S_IDLE);
  wire             fill   = (st == S_WAIT) && ram_rvalid;

  assign req_ready = (st == S_IDLE);
  assign rcl_valid = (st == S_RCL);
  assign rcl_node  = hold_q;
  assign rcl_line  = c_idx;
  assign ram_rd    = (st == S_FETCH);
  assign ram_line  = c_idx;
  assign rsp_valid = (st == S_RSP);
  assign rsp_dst   = cur_src;
  assign rsp_err   = err_q;
  assign rsp_addr  = cur_addr;
  assign rsp_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_src  <= '0;
      cur_addr <= '0;
      hold_q   <= '0;
      err_q    <= 1'b0;
      data_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          cur_src  <= req_src;
          cur_addr <= req_addr;
          if (a_home != NODE_ID) begin
            err_q  <= 1'b1;
            data_q <= '0;
            st     <= S_RSP;
          end else begin
            err_q <= 1'b0;
            if (dir_v[a_idx] && dir_h[a_idx] != req_src) begin
              hold_q <= dir_h[a_idx];
              st     <= S_RCL;
            end else begin
              st <= S_FETCH;
            end
          end
        end
        S_RCL:   if (rcl_ack) st <= S_FETCH;
        S_FETCH: st <= S_WAIT;
        S_WAIT:  if (ram_rvalid) begin
          data_q <= ram_rdata;
          st     <= S_RSP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) dir_v[i] <= 1'b0;
    end else if (fill) begin
      dir_v[c_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) dir_h[c_idx] <= cur_src;
  end

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R8
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (req_ready && !rsp_valid));
  // R6
  rcl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rcl_valid && !rcl_ack) |=> (rcl_valid && $stable(rcl_node) && $stable(rcl_line)));
  // R6
  rcl_no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rcl_valid |-> !ram_rd);
  // R6
  ack_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rcl_valid && rcl_ack) |=> ram_rd);
  // R4
  fill_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && ram_rvalid) |=> (rsp_valid && !rsp_err));
  // R3
  err_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_data == '0 && rsp_addr[31:24] != NODE_ID));
endmodule

// File: tb/tb_dir_home_ctrl.sv
module tb_dir_home_ctrl;
  localparam int CLK_P = 10;
  localparam int IDX_W = 4;
  localparam int DW    = 64;
  localparam logic [7:0] ME = 8'd36;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [7:0] req_src = 0;
  logic [31:0] req_addr = 0;
  logic rcl_valid, rcl_ack = 0;
  logic [7:0] rcl_node;
  logic [IDX_W-1:0] rcl_line, ram_line;
  logic ram_rd, ram_rvalid = 0;
  logic [DW-1:0] ram_rdata = 0, rsp_data;
  logic rsp_valid, rsp_err;
  logic [7:0] rsp_dst;
  logic [31:0] rsp_addr;

  int n_tests = 0, n_fail = 0;
  logic ref_v [1<<IDX_W];
  logic [7:0] ref_h [1<<IDX_W];

  always #(CLK_P/2) clk = ~clk;

  dir_home_ctrl #(.NODE_ID(ME), .IDX_W(IDX_W), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_addr(req_addr), .rcl_valid(rcl_valid),
    .rcl_node(rcl_node), .rcl_line(rcl_line), .rcl_ack(rcl_ack),
    .ram_rd(ram_rd), .ram_line(ram_line), .ram_rvalid(ram_rvalid),
    .ram_rdata(ram_rdata), .rsp_valid(rsp_valid), .rsp_dst(rsp_dst),
    .rsp_err(rsp_err), .rsp_addr(rsp_addr), .rsp_data(rsp_data));

  function automatic logic [DW-1:0] line_data(input logic [IDX_W-1:0] i);
    return {32'hA5A50000 | 32'(i), 32'(i) * 32'h9E3779B1};
  endfunction

  int rc_cnt = 0, rd_cnt = 0;
  logic [IDX_W-1:0] rd_line = 0;
  always @(negedge clk) begin
    rcl_ack <= 1'b0;
    if (rcl_valid) begin
      rc_cnt <= rc_cnt + 1;
      if (rc_cnt == 3) rcl_ack <= 1'b1;
    end else rc_cnt <= 0;
    ram_rvalid <= 1'b0;
    if (ram_rd) begin
      rd_cnt <= 1; rd_line <= ram_line;
    end else if (rd_cnt == 2) begin
      ram_rvalid <= 1'b1; ram_rdata <= line_data(rd_line); rd_cnt <= 0;
    end else if (rd_cnt != 0) rd_cnt <= rd_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic [7:0] src, input logic [31:0] addr, input string tag);
    bit exp_err, exp_rcl, saw_rcl = 0, saw_rd = 0, overlap = 0, busy_rdy = 0;
    logic [7:0] exp_node = 0, got_node = 0;
    logic [IDX_W-1:0] idx = addr[6 +: IDX_W], got_rl = 0, got_rd = 0;
    int cyc = 0;
    exp_err = (addr[31:24] != ME);
    exp_rcl = !exp_err && ref_v[idx] && ref_h[idx] != src;
    exp_node = ref_h[idx];
    @(negedge clk);
    req_valid = 1; req_src = src; req_addr = addr;
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid && cyc < 60) begin
      if (req_ready) busy_rdy = 1;
      if (rcl_valid) begin saw_rcl = 1; got_node = rcl_node; got_rl = rcl_line; end
      if (ram_rd) begin saw_rd = 1; got_rd = ram_line; if (rcl_valid) overlap = 1; end
      cyc++;
      @(negedge clk);
    end
    check(cyc < 60, {tag, " R8 reply arrives"}, 64'(cyc), 60);
    check(!busy_rdy, {tag, " R8 ready low while busy"}, 64'(busy_rdy), 0);
    check(rsp_err == exp_err, {tag, " R3 err flag"}, 64'(rsp_err), 64'(exp_err));
    check(rsp_dst == src && rsp_addr == addr, {tag, " R4 dst/addr"}, {rsp_dst, rsp_addr}, {src, addr});
    check(saw_rcl == exp_rcl, {tag, " R5/R7 recall issued"}, 64'(saw_rcl), 64'(exp_rcl));
    check(!overlap, {tag, " R6 no read during recall"}, 64'(overlap), 0);
    if (exp_rcl)
      check(got_node == exp_node && got_rl == idx, {tag, " R5 recall target"},
            {got_node, 32'(got_rl)}, {exp_node, 32'(idx)});
    if (exp_err) begin
      check(!saw_rd && rsp_data == 0, {tag, " R3 no RAM read, zero data"}, rsp_data, 0);
    end else begin
      check(saw_rd && got_rd == idx, {tag, " R2/R4 RAM index"}, 64'(got_rd), 64'(idx));
      check(rsp_data == line_data(idx), {tag, " R4 reply data"}, rsp_data, line_data(idx));
      ref_v[idx] = 1; ref_h[idx] = src;
    end
    @(negedge clk);
    check(req_ready && !rsp_valid, {tag, " R8 back to idle"}, 64'(req_ready), 1);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < (1<<IDX_W); i++) begin ref_v[i] = 0; ref_h[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !ram_rd && !rcl_valid, "R1 reset outputs",
          {rsp_valid, ram_rd, rcl_valid, req_ready}, 4'b0001);
    do_req(8'd20, 32'h24000108, "R1 R2 example");
    do_req(8'd20, 32'h2400013C, "R7 same holder");
    do_req(8'd7,  32'h24000130, "R5 R6 recall");
    do_req(8'd9,  32'h25000100, "R3 foreign home");
    do_req(8'd9,  32'h24000100, "R3 dir unchanged probe");
    do_req(8'd3,  32'h24FFFFC0, "R2 top line");
    for (int k = 0; k < 300; k++) begin
      logic [31:0] a;
      logic [7:0] s;
      a = {ME, 18'($urandom_range(0, 40)), 6'($urandom)};
      if ($urandom_range(0, 9) == 0) a[31:24] = 8'($urandom_range(0, 35));
      s = 8'($urandom_range(0, 5));
      do_req(s, a, "random");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule